// File: doc/BRIEF.md
# Memory Protection Entry Register Bank

This block holds the control state of a physical-memory-protection unit. It stores a parameterised number of protection entries and one security-control register. Each entry has an 8-bit configuration byte and a full-width address register. Software reaches this state through a simple register port, with a write strobe and a combinational read path. The block decides which writes land, using the entry lock bits and the lockdown, whitelist and lock-bypass controls. It can also be built without the enhanced lockdown logic, in which case only the plain lock bit governs configuration writes.

Configuration bytes are packed into register words: four bytes per word when the word is 32 bits wide and eight when it is 64 bits wide. Every entry register is exported flat for the range decoder downstream. A one-cycle flush pulse tells the translation caches that the protection state really changed. This register port carries control traffic and has no back-pressure: every strobed write is either applied or dropped within one cycle.

Top module: `pmp_csr_bank`

## Requirements
- R1: After reset every configuration byte, every address register, the security register, the flush pulse and every read value are zero.
- R2: In a configuration word with select 0 and index r, byte i (bits 8i+7:8i) belongs to entry r*(XLEN/8)+i, both for writes and reads. Within a byte, bit 0 is read, bit 1 is write, bit 2 is execute, bits 4:3 are the address mode (0 off, 1 top-of-range, 2 four-byte, 3 power-of-two), and bit 7 is lock. Entry e is exported on cfg_o[8e+7:8e] and addr_o[XLEN*(e+1)-1:XLEN*e].
- R3: With ENHANCED=0, a configuration byte whose entry has its lock bit set does not change.
- R4: With ENHANCED=1, a configuration byte is accepted only when one of these holds: bypass is set; lockdown is clear and the entry is unlocked; lockdown is set and the new byte has lock set and execute clear; lockdown is set and the new byte has lock clear and its low three bits differ from 3'b110.
- R5: A write to an address register (select 1) is dropped while that entry is locked.
- R6: An address write to entry e is also dropped when entry e+1 is locked and in top-of-range mode. A locked successor in any other mode does not block it.
- R7: Writes that address entries at or above NUM_ENTRIES are ignored, and reads of those positions return zero.
- R8: In the security register (select 2), bit 0 is lockdown, bit 1 is whitelist and bit 2 is bypass. Once set, lockdown and whitelist cannot be cleared by a write. With ENHANCED=0 all three bits stay zero.
- R9: Bypass cannot go from 0 to 1 while any entry has its lock bit set. It can still be cleared.
- R10: flush_o is high for exactly one cycle after a write that changes a configuration byte, changes an address register, or changes lockdown or whitelist. A write that is dropped, rewrites the same value, or touches only bypass gives no pulse.
- R11: A write becomes visible on reads and exports at the clock edge that samples the strobe, not before. Reads are combinational from the stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_we | input | 1 | Write strobe, sampled on the rising edge |
| csr_wsel | input | 2 | Write target: 0 configuration word, 1 address, 2 security |
| csr_widx | input | IDX_W | Word index for configuration, entry index for address |
| csr_wdata | input | XLEN | Write data |
| csr_rsel | input | 2 | Read target, same encoding as csr_wsel |
| csr_ridx | input | IDX_W | Read index |
| csr_rdata | output | XLEN | Combinational read data |
| flush_o | output | 1 | One-cycle protection-changed pulse |
| sec_o | output | 3 | Security register {bypass, whitelist, lockdown} |
| cfg_o | output | NUM_ENTRIES*8 | All configuration bytes, entry 0 lowest |
| addr_o | output | NUM_ENTRIES*XLEN | All address registers, entry 0 lowest |

## Verification
Read data is combinational, so a read is checked a fraction of a nanosecond after its select and index settle. A write strobe is driven on a falling edge and sampled on the next rising edge. Both its effect on stored state and its flush pulse are therefore due one register stage later, and the bench checks them at the falling edge that follows. The bench also reads the target while the strobe is still pending and expects the old value then. Because the flush pulse lasts a single cycle, it is sampled in that one window only, and a missing or extra pulse shows up there.

// File: rtl/pmp_pkg.sv
package pmp_pkg;

  typedef enum logic [1:0] {
    SEL_CFG  = 2'd0,
    SEL_ADDR = 2'd1,
    SEL_SEC  = 2'd2,
    SEL_NONE = 2'd3
  } csr_sel_e;

  typedef enum logic [1:0] {
    AM_OFF   = 2'd0,
    AM_TOR   = 2'd1,
    AM_NA4   = 2'd2,
    AM_NAPOT = 2'd3
  } amode_e;

  // one entry's control byte, bit 7 down to bit 0
  typedef struct packed {
    logic       lock;
    logic [1:0] spare;
    amode_e     amode;
    logic       x;
    logic       w;
    logic       r;
  } ent_cfg_t;

  // security control, bit 2 down to bit 0
  typedef struct packed {
    logic bypass;
    logic whitelist;
    logic lockdown;
  } sec_t;

endpackage

// File: rtl/pmp_cfg_gate.sv
module pmp_cfg_gate
  import pmp_pkg::*;
#(
  parameter bit ENHANCED = 1'b1
) (
  input  ent_cfg_t cur_cfg,
  input  ent_cfg_t new_cfg,
  input  sec_t     sec,
  output logic     accept
);

  generate
    if (ENHANCED) begin : g_enh
      logic keep_x_off;
      logic open_path;
      logic lock_no_x;
      logic shared_ok;
      always_comb begin
        keep_x_off = ({new_cfg.x, new_cfg.w, new_cfg.r} != 3'b110);
        open_path  = !sec.lockdown && !cur_cfg.lock;
        lock_no_x  = sec.lockdown && new_cfg.lock && !new_cfg.x;
        shared_ok  = sec.lockdown && !new_cfg.lock && keep_x_off;
        accept     = sec.bypass || open_path || lock_no_x || shared_ok;
      end
    end else begin : g_plain
      logic unused_ok;
      assign unused_ok = ^{sec, new_cfg};
      assign accept    = !cur_cfg.lock;
    end
  endgenerate

endmodule

// File: rtl/pmp_entry.sv
module pmp_entry
  import pmp_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter bit ENHANCED = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  ent_cfg_t        cfg_wdata,
  input  logic            addr_we,
  input  logic [XLEN-1:0] addr_wdata,
  input  sec_t            sec,
  input  logic            succ_guard,
  output ent_cfg_t        cfg_q,
  output logic [XLEN-1:0] addr_q,
  output logic            changed
);

  logic cfg_ok;
  logic cfg_upd;
  logic addr_upd;

  pmp_cfg_gate #(.ENHANCED(ENHANCED)) u_gate (
    .cur_cfg (cfg_q),
    .new_cfg (cfg_wdata),
    .sec     (sec),
    .accept  (cfg_ok)
  );

  always_comb begin
    cfg_upd  = cfg_we && cfg_ok && (cfg_wdata != cfg_q);
    addr_upd = addr_we && !cfg_q.lock && !succ_guard && (addr_wdata != addr_q);
    changed  = cfg_upd || addr_upd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      addr_q <= '0;
    end else begin
      if (cfg_upd)  cfg_q  <= cfg_wdata;
      if (addr_upd) addr_q <= addr_wdata;
    end
  end

  // R5: a locked entry keeps its address
  a_r5_locked_addr_held : assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q.lock |=> $stable(addr_q));

  // R6: a locked top-of-range successor guards this address
  a_r6_succ_guard_held : assert property (@(posedge clk) disable iff (!rst_n)
    succ_guard |=> $stable(addr_q));

  generate
    if (!ENHANCED) begin : g_plain_chk
      // R3: plain lock freezes the control byte
      a_r3_plain_lock_held : assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.lock |=> $stable(cfg_q));
    end
  endgenerate

endmodule

// File: rtl/pmp_sec_reg.sv
module pmp_sec_reg
  import pmp_pkg::*;
#(
  parameter bit ENHANCED = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic we,
  input  sec_t wdata,
  input  logic any_lock,
  output sec_t sec_q,
  output logic changed
);

  sec_t nxt;

  always_comb begin
    nxt = wdata;
    if (!sec_q.bypass && any_lock) nxt.bypass = 1'b0;
    if (ENHANCED) begin
      nxt.lockdown  = nxt.lockdown  | sec_q.lockdown;
      nxt.whitelist = nxt.whitelist | sec_q.whitelist;
    end else begin
      nxt = '0;
    end
    changed = we && ((nxt.lockdown != sec_q.lockdown) ||
                     (nxt.whitelist != sec_q.whitelist));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sec_q <= '0;
    else if (we) sec_q <= nxt;
  end

  // R8: sticky lockdown and whitelist
  a_r8_lockdown_sticky : assert property (@(posedge clk) disable iff (!rst_n)
    sec_q.lockdown |=> sec_q.lockdown);
  a_r8_whitelist_sticky : assert property (@(posedge clk) disable iff (!rst_n)
    sec_q.whitelist |=> sec_q.whitelist);

  // R9: bypass cannot rise while an entry is locked
  a_r9_bypass_no_rise : assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_q.bypass && any_lock) |=> !sec_q.bypass);

endmodule

// File: rtl/pmp_csr_bank.sv
module pmp_csr_bank
  import pmp_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int XLEN        = 32,
  parameter int IDX_W       = 8,
  parameter bit ENHANCED    = 1'b1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        csr_we,
  input  logic [1:0]                  csr_wsel,
  input  logic [IDX_W-1:0]            csr_widx,
  input  logic [XLEN-1:0]             csr_wdata,
  input  logic [1:0]                  csr_rsel,
  input  logic [IDX_W-1:0]            csr_ridx,
  output logic [XLEN-1:0]             csr_rdata,
  output logic                        flush_o,
  output logic [2:0]                  sec_o,
  output logic [NUM_ENTRIES*8-1:0]    cfg_o,
  output logic [NUM_ENTRIES*XLEN-1:0] addr_o
);

  localparam int FPC = XLEN / 8;

  csr_sel_e        wsel;
  csr_sel_e        rsel;
  ent_cfg_t        cfg_q   [NUM_ENTRIES];
  logic [XLEN-1:0] addr_q  [NUM_ENTRIES];
  logic            ent_chg [NUM_ENTRIES];
  logic            lock_v  [NUM_ENTRIES];
  logic            guard_v [NUM_ENTRIES];
  sec_t            sec_q;
  logic            sec_chg;
  logic            any_lock;
  logic            any_chg;

  assign wsel = csr_sel_e'(csr_wsel);
  assign rsel = csr_sel_e'(csr_rsel);

  generate
    for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_ent
      logic cfg_hit;
      logic addr_hit;

      assign cfg_hit  = csr_we && (wsel == SEL_CFG)  && (int'(csr_widx) == e / FPC);
      assign addr_hit = csr_we && (wsel == SEL_ADDR) && (int'(csr_widx) == e);

      if (e + 1 < NUM_ENTRIES) begin : g_succ
        assign guard_v[e] = cfg_q[e+1].lock && (cfg_q[e+1].amode == AM_TOR);
      end else begin : g_last
        assign guard_v[e] = 1'b0;
      end

      pmp_entry #(.XLEN(XLEN), .ENHANCED(ENHANCED)) u_ent (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_hit),
        .cfg_wdata  (ent_cfg_t'(csr_wdata[(e % FPC)*8 +: 8])),
        .addr_we    (addr_hit),
        .addr_wdata (csr_wdata),
        .sec        (sec_q),
        .succ_guard (guard_v[e]),
        .cfg_q      (cfg_q[e]),
        .addr_q     (addr_q[e]),
        .changed    (ent_chg[e])
      );

      assign lock_v[e]                 = cfg_q[e].lock;
      assign cfg_o[e*8 +: 8]           = cfg_q[e];
      assign addr_o[e*XLEN +: XLEN]    = addr_q[e];
    end
  endgenerate

  always_comb begin
    any_lock = 1'b0;
    any_chg  = 1'b0;
    for (int e = 0; e < NUM_ENTRIES; e++) begin
      any_lock = any_lock | lock_v[e];
      any_chg  = any_chg  | ent_chg[e];
    end
  end

  pmp_sec_reg #(.ENHANCED(ENHANCED)) u_sec (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (csr_we && (wsel == SEL_SEC)),
    .wdata    (sec_t'(csr_wdata[2:0])),
    .any_lock (any_lock),
    .sec_q    (sec_q),
    .changed  (sec_chg)
  );

  assign sec_o = sec_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flush_o <= 1'b0;
    else        flush_o <= any_chg || sec_chg;
  end

  // combinational read path; positions beyond the bank stay zero
  always_comb begin
    csr_rdata = '0;
    unique case (rsel)
      SEL_CFG: begin
        for (int e = 0; e < NUM_ENTRIES; e++) begin
          if (int'(csr_ridx) == e / FPC) csr_rdata[(e % FPC)*8 +: 8] = cfg_q[e];
        end
      end
      SEL_ADDR: begin
        for (int e = 0; e < NUM_ENTRIES; e++) begin
          if (int'(csr_ridx) == e) csr_rdata = addr_q[e];
        end
      end
      SEL_SEC:  csr_rdata = XLEN'(sec_q);
      default:  csr_rdata = '0;
    endcase
  end

  // R10: every change of exported state comes with a flush pulse
  a_r10_cfg_change_flush : assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_o) |-> flush_o);
  a_r10_addr_change_flush : assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(addr_o) |-> flush_o);
  a_r10_sec_change_flush : assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sec_o[1:0]) |-> flush_o);

endmodule

// File: tb/sim_pmp_csr_bank.sv
`timescale 1ns/1ps
module sim_pmp_csr_bank;

  localparam int N  = 6;
  localparam int XL = 32;
  localparam int NV = 23;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we0 = 1'b0, we1 = 1'b0;
  logic [1:0]  wsel = '0, rsel = '0;
  logic [7:0]  widx = '0, ridx = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rd0, rd1;
  logic        fl0, fl1;
  logic [2:0]  sec0, sec1;
  logic [N*8-1:0]  cfg0, cfg1;
  logic [N*XL-1:0] adr0, adr1;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  pmp_csr_bank #(.NUM_ENTRIES(N), .XLEN(XL), .IDX_W(8), .ENHANCED(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .csr_we(we0), .csr_wsel(wsel), .csr_widx(widx),
    .csr_wdata(wdata), .csr_rsel(rsel), .csr_ridx(ridx), .csr_rdata(rd0),
    .flush_o(fl0), .sec_o(sec0), .cfg_o(cfg0), .addr_o(adr0));

  pmp_csr_bank #(.NUM_ENTRIES(N), .XLEN(XL), .IDX_W(8), .ENHANCED(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .csr_we(we1), .csr_wsel(wsel), .csr_widx(widx),
    .csr_wdata(wdata), .csr_rsel(rsel), .csr_ridx(ridx), .csr_rdata(rd1),
    .flush_o(fl1), .sec_o(sec1), .cfg_o(cfg1), .addr_o(adr1));

  // {req, sel, idx, wdata, expected read, expected flush}
  localparam logic [78:0] VEC [NV] = '{
    {4'd11, 2'd1, 8'd0, 32'h0000_0100, 32'h0000_0100, 1'b1},  // R11 addr write
    {4'd10, 2'd1, 8'd0, 32'h0000_0100, 32'h0000_0100, 1'b0},  // R10 same value
    {4'd2,  2'd0, 8'd0, 32'h0000_190B, 32'h0000_190B, 1'b1},  // R2 packing
    {4'd7,  2'd0, 8'd1, 32'hAABB_1103, 32'h0000_1103, 1'b1},  // R7 partial word
    {4'd7,  2'd0, 8'd2, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0},  // R7 beyond bank
    {4'd7,  2'd1, 8'd6, 32'h0000_0005, 32'h0000_0000, 1'b0},  // R7 addr beyond
    {4'd10, 2'd2, 8'd0, 32'h0000_0004, 32'h0000_0004, 1'b0},  // R10 bypass only
    {4'd2,  2'd0, 8'd0, 32'h0000_198B, 32'h0000_198B, 1'b1},  // R2 lock entry 0
    {4'd9,  2'd2, 8'd0, 32'h0000_0000, 32'h0000_0000, 1'b0},  // R9 bypass clears
    {4'd9,  2'd2, 8'd0, 32'h0000_0004, 32'h0000_0000, 1'b0},  // R9 no rise
    {4'd4,  2'd0, 8'd0, 32'h0000_1900, 32'h0000_198B, 1'b0},  // R4 locked dropped
    {4'd5,  2'd1, 8'd0, 32'h0000_0200, 32'h0000_0100, 1'b0},  // R5 locked addr
    {4'd4,  2'd0, 8'd1, 32'h0000_8803, 32'h0000_8803, 1'b1},  // R4 open path
    {4'd6,  2'd1, 8'd4, 32'h0000_0300, 32'h0000_0000, 1'b0},  // R6 TOR guard
    {4'd6,  2'd1, 8'd1, 32'h0000_0040, 32'h0000_0040, 1'b1},  // R6 no guard
    {4'd2,  2'd0, 8'd0, 32'h9000_198B, 32'h9000_198B, 1'b1},  // R2 byte 3
    {4'd6,  2'd1, 8'd2, 32'h0000_0077, 32'h0000_0077, 1'b1},  // R6 NA4 succ
    {4'd8,  2'd2, 8'd0, 32'h0000_0003, 32'h0000_0003, 1'b1},  // R8 set sticky
    {4'd8,  2'd2, 8'd0, 32'h0000_0000, 32'h0000_0003, 1'b0},  // R8 no clear
    {4'd4,  2'd0, 8'd1, 32'h0000_8806, 32'h0000_8803, 1'b0},  // R4 W|X shared
    {4'd4,  2'd0, 8'd1, 32'h0000_8807, 32'h0000_8807, 1'b1},  // R4 shared ok
    {4'd4,  2'd0, 8'd1, 32'h0000_8C07, 32'h0000_8807, 1'b0},  // R4 lock with X
    {4'd4,  2'd0, 8'd1, 32'h0000_8907, 32'h0000_8907, 1'b1}   // R4 lock no X
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input bit which, input logic [1:0] s, input logic [7:0] i,
                    input logic [31:0] d);
    @(negedge clk);
    wsel = s; widx = i; wdata = d;
    if (which) we1 = 1'b1; else we0 = 1'b1;
    @(negedge clk);
    we0 = 1'b0; we1 = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, input logic [7:0] i);
    rsel = s; ridx = i;
    #0.5;
  endtask

  initial begin
    #(4 * 50000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(2'd0, 8'd0); chk("R1 cfg word", rd0, 0);
    rd(2'd1, 8'd0); chk("R1 addr", rd0, 0);
    rd(2'd2, 8'd0); chk("R1 sec", rd0, 0);
    chk("R1 flush", fl0, 0);
    chk("R1 exports", {cfg0, adr0[31:0]}, 0);

    // R11 value not visible before the sampling edge
    @(negedge clk);
    wsel = 2'd1; widx = 8'd3; wdata = 32'h55; we0 = 1'b1;
    rd(2'd1, 8'd3); chk("R11 before edge", rd0, 0);
    @(negedge clk);
    we0 = 1'b0;
    rd(2'd1, 8'd3); chk("R11 after edge", rd0, 32'h55);
    chk("R2 addr export", adr0[3*32 +: 32], 32'h55);

    // table walk on the enhanced instance
    for (int k = 0; k < NV; k++) begin
      logic [78:0] v;
      string tg;
      v = VEC[k];
      tg = $sformatf("R%0d row %0d", v[78:75], k);
      wr(1'b0, v[74:73], v[72:65], v[64:33]);
      chk({tg, " flush"}, fl0, v[0]);
      rd(v[74:73], v[72:65]);
      chk({tg, " read"}, rd0, v[32:1]);
    end
    @(negedge clk);
    chk("R10 pulse one cycle", fl0, 0);
    chk("R2 cfg export entry5", cfg0[5*8 +: 8], 8'h89);
    chk("R2 cfg export entry3", cfg0[3*8 +: 8], 8'h90);
    chk("R2 addr export entry2", adr0[2*32 +: 32], 32'h77);

    // plain instance
    wr(1'b1, 2'd2, 8'd0, 32'h7);
    rd(2'd2, 8'd0); chk("R8 plain sec zero", rd1, 0);
    chk("R8 plain flush", fl1, 0);
    wr(1'b1, 2'd0, 8'd0, 32'h80);
    chk("R2 plain flush", fl1, 1);
    rd(2'd0, 8'd0); chk("R2 plain lock", rd1, 32'h80);
    wr(1'b1, 2'd0, 8'd0, 32'h01);
    chk("R3 plain flush", fl1, 0);
    rd(2'd0, 8'd0); chk("R3 plain locked", rd1, 32'h80);
    wr(1'b1, 2'd1, 8'd0, 32'h9);
    rd(2'd1, 8'd0); chk("R5 plain addr", rd1, 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule